// File: doc/BRIEF.md
# Indexed Block Register Target for a Two-Wire Management Bus

This block is a slave-only target on a two-wire SMBus/I2C management bus. It gives a host access to a small bank of 8-bit configuration registers through indexed block transfers. The block itself does not store the registers. It emits a write strobe with an index and a data byte, and for reads it asks for a byte at an index. A neighbouring register bank answers that request in the same clock cycle.

SCL and SDA arrive from the pads. Each line first passes through a two-flop synchroniser and then through a glitch filter clocked by a faster system clock. Start, repeated start and stop conditions and the SCL edges are detected only after that filtering. The block pulls SDA low through an open-drain enable and changes that enable only while SCL is low.

Every write carries a starting offset, then a non-zero byte count, then that many data bytes. A read first writes the offset. It then issues a repeated start with the read address. The target answers with a byte count, then data bytes from the offset upward, until the host NACKs the last byte it wants.

Top module: `smb_idx_slave`

## Requirements
- R1: The target acknowledges only the write address byte D2h (7-bit address 1101001, R/W bit 0) after a start. Any other address byte is NACKed (SDA left released in the ack slot), and the rest of that transfer produces no strobe.
- R2: In a write, the offset byte and the count byte N are acknowledged. Each of the next N data bytes is acknowledged and produces one wr_stb pulse, with wr_idx equal to the offset plus the byte position and wr_data equal to the byte.
- R3: A write count byte of 00h is NACKed. The target then goes idle and produces no write strobe.
- R4: A data byte beyond the N announced in the count byte is NACKed and is not written.
- R5: After D2h, the offset, a repeated start and D3h, the target first sends a byte count equal to 7 minus the offset (0 when the offset is 7 or more). It then sends register contents starting at the offset, index ascending, MSB first. Each byte fetched from the bank raises rd_req with rd_idx on the fetched index.
- R6: A read byte for an index of 7 or above is FFh and raises no rd_req.
- R7: When the host NACKs a read byte, the target releases SDA and goes idle. A following transfer is served normally.
- R8: The read address D3h is acknowledged only after a repeated start that directly follows an acknowledged offset byte. D3h after a plain start, or after a repeated start at any other point, is NACKed.
- R9: A start or stop detected in any state aborts the current transfer. Bytes acknowledged before the abort stay written, and bytes not yet complete are dropped.
- R10: A pulse on SDA or SCL that lasts fewer than GLITCH (default 3) system clocks is ignored. It neither aborts a transfer nor alters a byte.
- R11: sda_oe changes only while the filtered SCL is low, and it is released after every stop.
- R12: Out of reset, sda_oe, wr_stb and rd_req are low.
- R13: Data bytes inside the announced count but aimed at index 7 or above are acknowledged, and no wr_stb is issued for them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than SCL |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | SCL level from the pad |
| sda_i | input | 1 | SDA level from the pad (wired-AND of all drivers) |
| sda_oe | output | 1 | 1 pulls SDA low; 0 releases it |
| wr_stb | output | 1 | One-cycle write strobe to the register bank |
| wr_idx | output | IDXW | Register index for the write strobe |
| wr_data | output | 8 | Data byte for the write strobe |
| rd_req | output | 1 | One-cycle request for the byte at rd_idx |
| rd_idx | output | IDXW | Current auto-incrementing register index |
| rd_data | input | 8 | Register contents at rd_idx, valid in the same cycle |

## Verification
A wrong byte phase or bit count shows at the ports within one SCL period. The ack slot lands in the wrong place, or SDA stays pulled low into the host's next bit, and the host's next ack sample sees the error. An index that increments wrongly is not visible on a write until a later read returns a byte from the wrong location. Read-back after every random write is therefore what exposes it. A missed abort or a glitch that gets through shows up as NACKed bytes and as register contents that differ from the model once the next transfer completes.

// File: rtl/smb_idx_pkg.sv
package smb_idx_pkg;

   // bit-level phase of the serial engine
   typedef enum logic [2:0] {
      PH_IDLE,
      PH_RX,
      PH_ACK,
      PH_TX,
      PH_MACK
   } phase_t;

   // which byte of the transfer is being handled
   typedef enum logic [2:0] {
      ST_ADDR,
      ST_OFFS,
      ST_CNT,
      ST_WDATA,
      ST_RCNT,
      ST_RDATA
   } stage_t;

endpackage

// File: rtl/smb_line_filt.sv
module smb_line_filt #(
   parameter int GLITCH = 3
) (
   input  logic clk,
   input  logic rst_n,
   input  logic line_i,
   output logic line_o
);

   logic [1:0] sync_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sync_q <= 2'b11;
      else        sync_q <= {sync_q[0], line_i};
   end

   generate
      if (GLITCH == 0) begin : g_bypass
         assign line_o = sync_q[1];
      end else begin : g_filt
         localparam int CW = $clog2(GLITCH + 1);
         logic [CW-1:0] cnt_q;
         logic          out_q;

         // the output follows only after GLITCH consecutive differing samples
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               cnt_q <= '0;
               out_q <= 1'b1;
            end else if (sync_q[1] == out_q) begin
               cnt_q <= '0;
            end else if (cnt_q == CW'(GLITCH - 1)) begin
               cnt_q <= '0;
               out_q <= sync_q[1];
            end else begin
               cnt_q <= cnt_q + 1'b1;
            end
         end
         assign line_o = out_q;
      end
   endgenerate

endmodule

// File: rtl/smb_bus_cond.sv
module smb_bus_cond (
   input  logic clk,
   input  logic rst_n,
   input  logic scl_f,
   input  logic sda_f,
   output logic scl_rise,
   output logic scl_fall,
   output logic start_det,
   output logic stop_det
);

   logic scl_q, sda_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         scl_q <= 1'b1;
         sda_q <= 1'b1;
      end else begin
         scl_q <= scl_f;
         sda_q <= sda_f;
      end
   end

   assign scl_rise  =  scl_f & ~scl_q;
   assign scl_fall  = ~scl_f &  scl_q;
   // SDA moving while SCL is held high marks a bus condition
   assign start_det =  scl_f &  scl_q &  sda_q & ~sda_f;
   assign stop_det  =  scl_f &  scl_q & ~sda_q &  sda_f;

endmodule

// File: rtl/smb_idx_fsm.sv
module smb_idx_fsm
   import smb_idx_pkg::*;
#(
   parameter logic [6:0] DEV_ADDR = 7'b1101001,
   parameter int         NREG     = 7,
   parameter int         IDXW     = 8
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            scl_rise,
   input  logic            scl_fall,
   input  logic            sda_f,
   input  logic            start_det,
   input  logic            stop_det,
   input  logic [7:0]      rd_data,
   output logic            sda_oe,
   output logic            wr_stb,
   output logic [IDXW-1:0] wr_idx,
   output logic [7:0]      wr_data,
   output logic            rd_req,
   output logic [IDXW-1:0] rd_idx
);

   localparam logic [IDXW-1:0] NREG_I = IDXW'(NREG);
   localparam logic [7:0]      WADDR  = {DEV_ADDR, 1'b0};
   localparam logic [7:0]      RADDR  = {DEV_ADDR, 1'b1};

   phase_t          phase_q;
   stage_t          stage_q;
   logic [3:0]      bcnt_q;
   logic [7:0]      shreg_q;
   logic [7:0]      txsh_q;
   logic [IDXW-1:0] idx_q;
   logic [7:0]      rem_q;
   logic            off_ok_q;   // offset just acked: a repeated start may follow
   logic            rs_ok_q;    // current address byte follows such a repeated start
   logic            nack_q;
   logic            oe_q;
   logic            mack_q;
   logic            wr_stb_q;
   logic [IDXW-1:0] wr_idx_q;
   logic [7:0]      wr_data_q;

   logic            in_rng;
   logic [7:0]      rcnt_c;
   logic [7:0]      rbyte_c;

   always_comb begin
      in_rng  = (idx_q < NREG_I);
      rcnt_c  = in_rng ? 8'(NREG_I - idx_q) : 8'h00;
      rbyte_c = in_rng ? rd_data : 8'hFF;
   end

   assign rd_req = (phase_q == PH_MACK) && scl_fall && mack_q && in_rng;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase_q   <= PH_IDLE;
         stage_q   <= ST_ADDR;
         bcnt_q    <= '0;
         shreg_q   <= '0;
         txsh_q    <= '0;
         idx_q     <= '0;
         rem_q     <= '0;
         off_ok_q  <= 1'b0;
         rs_ok_q   <= 1'b0;
         nack_q    <= 1'b0;
         oe_q      <= 1'b0;
         mack_q    <= 1'b0;
         wr_stb_q  <= 1'b0;
         wr_idx_q  <= '0;
         wr_data_q <= '0;
      end else begin
         wr_stb_q <= 1'b0;
         if (start_det) begin
            phase_q  <= PH_RX;
            stage_q  <= ST_ADDR;
            bcnt_q   <= '0;
            oe_q     <= 1'b0;
            rs_ok_q  <= off_ok_q;
            off_ok_q <= 1'b0;
         end else if (stop_det) begin
            phase_q  <= PH_IDLE;
            oe_q     <= 1'b0;
            off_ok_q <= 1'b0;
            rs_ok_q  <= 1'b0;
         end else begin
            unique case (phase_q)
               PH_RX: begin
                  if (scl_rise && bcnt_q != 4'd8) begin
                     shreg_q <= {shreg_q[6:0], sda_f};
                     bcnt_q  <= bcnt_q + 1'b1;
                  end else if (scl_fall && bcnt_q == 4'd8) begin
                     phase_q  <= PH_ACK;
                     nack_q   <= 1'b0;
                     oe_q     <= 1'b1;
                     off_ok_q <= 1'b0;
                     case (stage_q)
                        ST_ADDR: begin
                           rs_ok_q <= 1'b0;
                           if (shreg_q == WADDR) begin
                              stage_q <= ST_OFFS;
                           end else if (shreg_q == RADDR && rs_ok_q) begin
                              stage_q <= ST_RCNT;
                           end else begin
                              oe_q   <= 1'b0;
                              nack_q <= 1'b1;
                           end
                        end
                        ST_OFFS: begin
                           idx_q    <= IDXW'(shreg_q);
                           off_ok_q <= 1'b1;
                           stage_q  <= ST_CNT;
                        end
                        ST_CNT: begin
                           if (shreg_q == 8'h00) begin
                              oe_q   <= 1'b0;
                              nack_q <= 1'b1;
                           end else begin
                              rem_q   <= shreg_q;
                              stage_q <= ST_WDATA;
                           end
                        end
                        ST_WDATA: begin
                           if (rem_q != 8'h00) begin
                              rem_q <= rem_q - 1'b1;
                              idx_q <= idx_q + 1'b1;
                              if (in_rng) begin
                                 wr_stb_q  <= 1'b1;
                                 wr_idx_q  <= idx_q;
                                 wr_data_q <= shreg_q;
                              end
                           end else begin
                              oe_q   <= 1'b0;
                              nack_q <= 1'b1;
                           end
                        end
                        default: begin
                           oe_q   <= 1'b0;
                           nack_q <= 1'b1;
                        end
                     endcase
                  end
               end
               PH_ACK: begin
                  if (scl_fall) begin
                     bcnt_q <= '0;
                     if (nack_q) begin
                        phase_q <= PH_IDLE;
                        oe_q    <= 1'b0;
                     end else if (stage_q == ST_RCNT) begin
                        txsh_q  <= rcnt_c;
                        oe_q    <= ~rcnt_c[7];
                        phase_q <= PH_TX;
                        stage_q <= ST_RDATA;
                     end else begin
                        oe_q    <= 1'b0;
                        phase_q <= PH_RX;
                     end
                  end
               end
               PH_TX: begin
                  if (scl_fall) begin
                     if (bcnt_q == 4'd7) begin
                        oe_q    <= 1'b0;
                        phase_q <= PH_MACK;
                     end else begin
                        bcnt_q <= bcnt_q + 1'b1;
                        txsh_q <= {txsh_q[6:0], 1'b0};
                        oe_q   <= ~txsh_q[6];
                     end
                  end
               end
               PH_MACK: begin
                  if (scl_rise) begin
                     mack_q <= ~sda_f;
                  end else if (scl_fall) begin
                     bcnt_q <= '0;
                     if (mack_q) begin
                        txsh_q  <= rbyte_c;
                        oe_q    <= ~rbyte_c[7];
                        idx_q   <= idx_q + 1'b1;
                        phase_q <= PH_TX;
                     end else begin
                        phase_q <= PH_IDLE;
                        oe_q    <= 1'b0;
                     end
                  end
               end
               default: ;
            endcase
         end
      end
   end

   assign sda_oe  = oe_q;
   assign wr_stb  = wr_stb_q;
   assign wr_idx  = wr_idx_q;
   assign wr_data = wr_data_q;
   assign rd_idx  = idx_q;

endmodule

// File: rtl/smb_idx_slave.sv
module smb_idx_slave #(
   parameter logic [6:0] DEV_ADDR = 7'b1101001,
   parameter int         NREG     = 7,
   parameter int         IDXW     = 8,
   parameter int         GLITCH   = 3
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            scl_i,
   input  logic            sda_i,
   output logic            sda_oe,
   output logic            wr_stb,
   output logic [IDXW-1:0] wr_idx,
   output logic [7:0]      wr_data,
   output logic            rd_req,
   output logic [IDXW-1:0] rd_idx,
   input  logic [7:0]      rd_data
);

   localparam int NLINE = 2;

   generate
      if (IDXW < 1 || IDXW > 8) begin : g_bad_idxw
         $error("smb_idx_slave: IDXW must lie in 1..8");
      end
      if (NREG < 1 || NREG >= (1 << IDXW)) begin : g_bad_nreg
         $error("smb_idx_slave: NREG must be at least 1 and below 2**IDXW");
      end
      if (GLITCH < 0) begin : g_bad_glitch
         $error("smb_idx_slave: GLITCH must not be negative");
      end
   endgenerate

   logic [NLINE-1:0] raw_lines;
   logic [NLINE-1:0] flt_lines;
   logic             scl_f, sda_f;
   logic             scl_rise, scl_fall, start_det, stop_det;

   assign raw_lines = {sda_i, scl_i};

   for (genvar g = 0; g < NLINE; g++) begin : g_line
      smb_line_filt #(.GLITCH(GLITCH)) u_filt (
         .clk    (clk),
         .rst_n  (rst_n),
         .line_i (raw_lines[g]),
         .line_o (flt_lines[g])
      );
   end

   assign scl_f = flt_lines[0];
   assign sda_f = flt_lines[1];

   smb_bus_cond u_cond (
      .clk       (clk),
      .rst_n     (rst_n),
      .scl_f     (scl_f),
      .sda_f     (sda_f),
      .scl_rise  (scl_rise),
      .scl_fall  (scl_fall),
      .start_det (start_det),
      .stop_det  (stop_det)
   );

   smb_idx_fsm #(
      .DEV_ADDR (DEV_ADDR),
      .NREG     (NREG),
      .IDXW     (IDXW)
   ) u_fsm (
      .clk       (clk),
      .rst_n     (rst_n),
      .scl_rise  (scl_rise),
      .scl_fall  (scl_fall),
      .sda_f     (sda_f),
      .start_det (start_det),
      .stop_det  (stop_det),
      .rd_data   (rd_data),
      .sda_oe    (sda_oe),
      .wr_stb    (wr_stb),
      .wr_idx    (wr_idx),
      .wr_data   (wr_data),
      .rd_req    (rd_req),
      .rd_idx    (rd_idx)
   );

endmodule

// File: rtl/smb_idx_slave_chk.sv
module smb_idx_slave_chk #(
   parameter int NREG = 7,
   parameter int IDXW = 8
) (
   input logic            clk,
   input logic            rst_n,
   input logic            scl_f,
   input logic            stop_det,
   input logic            sda_oe,
   input logic            wr_stb,
   input logic [IDXW-1:0] wr_idx,
   input logic            rd_req,
   input logic [7:0]      rd_data
);

   AST_OE_SCL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(sda_oe) |-> !scl_f);                                   // R11

   AST_STOP_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
      stop_det |=> !sda_oe);                                          // R11

   AST_WSTB_ACKED: assert property (@(posedge clk) disable iff (!rst_n)
      wr_stb |-> sda_oe);                                             // R2

   AST_WSTB_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      wr_stb |=> !wr_stb);                                            // R2

   AST_WIDX_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
      wr_stb |-> (wr_idx < IDXW'(NREG)));                             // R13

   AST_RD_MSB_DRIVEN: assert property (@(posedge clk) disable iff (!rst_n)
      rd_req |=> (sda_oe == !$past(rd_data[7])));                     // R5

   AST_NO_RW_OVERLAP: assert property (@(posedge clk) disable iff (!rst_n)
      !(wr_stb && rd_req));                                           // R6

endmodule

bind smb_idx_slave smb_idx_slave_chk #(.NREG(NREG), .IDXW(IDXW)) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .scl_f    (scl_f),
   .stop_det (stop_det),
   .sda_oe   (sda_oe),
   .wr_stb   (wr_stb),
   .wr_idx   (wr_idx),
   .rd_req   (rd_req),
   .rd_data  (rd_data)
);

// File: tb/smb_idx_slave_tb.sv
module smb_idx_slave_tb;

   localparam int NREG = 7;
   localparam int IDXW = 8;
   localparam int Q    = 12;   // system clocks per quarter SCL period

   logic clk = 1'b0;
   always #2 clk = ~clk;

   logic            rst_n = 1'b0;
   logic            m_scl = 1'b1;
   logic            m_sda = 1'b1;
   logic            glitch_n = 1'b1;
   logic            sda_line;
   logic            sda_oe, wr_stb, rd_req;
   logic [IDXW-1:0] wr_idx, rd_idx;
   logic [7:0]      wr_data, rd_data;

   assign sda_line = m_sda & glitch_n & ~sda_oe;

   smb_idx_slave #(.NREG(NREG), .IDXW(IDXW)) u_dut (
      .clk(clk), .rst_n(rst_n), .scl_i(m_scl), .sda_i(sda_line),
      .sda_oe(sda_oe), .wr_stb(wr_stb), .wr_idx(wr_idx), .wr_data(wr_data),
      .rd_req(rd_req), .rd_idx(rd_idx), .rd_data(rd_data)
   );

   // register bank next to the block, plus strobe counters
   logic [7:0] bank [NREG];
   int         stb_cnt = 0;
   int         req_cnt = 0;

   always @(posedge clk) begin
      if (!rst_n) begin
         for (int i = 0; i < NREG; i++) bank[i] <= 8'h00;
      end else begin
         if (wr_stb) begin
            stb_cnt <= stb_cnt + 1;
            if (wr_idx < NREG) bank[wr_idx] <= wr_data;
         end
         if (rd_req) req_cnt <= req_cnt + 1;
      end
   end
   assign rd_data = (rd_idx < NREG) ? bank[rd_idx] : 8'h00;

   logic [7:0] exp_bank [NREG];
   logic [7:0] wbuf [16];
   logic [7:0] rbuf [16];
   int n_chk  = 0;
   int n_fail = 0;

   task automatic check(input string req, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   function automatic int exp_count(input int off);
      return (off < NREG) ? NREG - off : 0;
   endfunction

   function automatic int exp_rd(input int idx);
      return (idx < NREG) ? int'(exp_bank[idx]) : 8'hFF;
   endfunction

   // expected effect of a write: returns the number of strobes
   function automatic int exp_write(input int off, input int cnt, input int nsend);
      int s = 0;
      for (int i = 0; i < nsend && i < cnt; i++) begin
         if (off + i < NREG) begin
            exp_bank[off + i] = wbuf[i];
            s++;
         end
      end
      return s;
   endfunction

   task automatic qw();
      repeat (Q) @(negedge clk);
   endtask

   task automatic m_start();
      m_sda = 1'b1; qw();
      m_scl = 1'b1; qw();
      m_sda = 1'b0; qw();
      m_scl = 1'b0; qw();
   endtask

   task automatic m_stop();
      m_sda = 1'b0; qw();
      m_scl = 1'b1; qw();
      m_sda = 1'b1; qw();
   endtask

   task automatic m_wbyte(input logic [7:0] b, input int gbit, output bit ack);
      for (int i = 7; i >= 0; i--) begin
         m_sda = b[i]; qw();
         m_scl = 1'b1; qw();
         if (i == gbit) begin
            glitch_n = 1'b0;
            repeat (2) @(negedge clk);
            glitch_n = 1'b1;
            repeat (Q - 2) @(negedge clk);
         end else begin
            qw();
         end
         m_scl = 1'b0; qw();
      end
      m_sda = 1'b1; qw();
      m_scl = 1'b1; qw();
      ack = !sda_line;
      qw();
      m_scl = 1'b0; qw();
   endtask

   task automatic m_rbyte(input bit give_ack, output logic [7:0] b);
      m_sda = 1'b1;
      for (int i = 7; i >= 0; i--) begin
         qw();
         m_scl = 1'b1; qw();
         b[i] = sda_line;
         qw();
         m_scl = 1'b0;
      end
      qw();
      m_sda = give_ack ? 1'b0 : 1'b1; qw();
      m_scl = 1'b1; qw(); qw();
      m_scl = 1'b0; qw();
      m_sda = 1'b1;
   endtask

   // acks: [0] address, [1] offset, [2] count, [3+i] data byte i
   task automatic write_xfer(input int off, input int cnt, input int nsend,
                             input int gbit, output bit [19:0] acks);
      bit a;
      acks = '0;
      m_start();
      m_wbyte(8'hD2, -1, a); acks[0] = a;
      m_wbyte(8'(off), -1, a); acks[1] = a;
      m_wbyte(8'(cnt), -1, a); acks[2] = a;
      if (a) begin
         for (int i = 0; i < nsend; i++) begin
            m_wbyte(wbuf[i], (i == 0) ? gbit : -1, a);
            acks[3 + i] = a;
         end
      end
      m_stop();
   endtask

   // acks: [0] D2h, [1] offset, [2] D3h
   task automatic read_xfer(input int off, input int nread,
                            output logic [7:0] rcount, output bit [2:0] acks);
      bit a;
      logic [7:0] b;
      m_start();
      m_wbyte(8'hD2, -1, a); acks[0] = a;
      m_wbyte(8'(off), -1, a); acks[1] = a;
      m_start();
      m_wbyte(8'hD3, -1, a); acks[2] = a;
      m_rbyte(1'b1, rcount);
      for (int i = 0; i < nread; i++) begin
         m_rbyte(i < nread - 1, b);
         rbuf[i] = b;
      end
      m_stop();
   endtask

   task automatic cmp_bank(input string req);
      for (int i = 0; i < NREG; i++) check(req, int'(bank[i]), int'(exp_bank[i]));
   endtask

   task automatic write_and_check(input string req, input int off, input int cnt,
                                  input int nsend, input int gbit);
      bit [19:0] acks;
      int s0, se;
      s0 = stb_cnt;
      se = exp_write(off, cnt, nsend);
      write_xfer(off, cnt, nsend, gbit, acks);
      check({req, " addr/offset/count ack"}, int'(acks[2:0]), 7);
      for (int i = 0; i < nsend; i++)
         check({req, " data ack"}, int'(acks[3 + i]), (i < cnt) ? 1 : 0);
      check({req, " strobes"}, stb_cnt - s0, se);
      cmp_bank(req);
   endtask

   task automatic read_and_check(input string req, input int off, input int nread);
      logic [7:0] rc;
      bit [2:0]   acks;
      int r0, re;
      r0 = req_cnt;
      re = 0;
      for (int i = 0; i < nread; i++) if (off + i < NREG) re++;
      read_xfer(off, nread, rc, acks);
      check({req, " read acks"}, int'(acks), 7);
      check({req, " R5 byte count"}, int'(rc), exp_count(off));
      for (int i = 0; i < nread; i++)
         check({req, " R5/R6 data"}, int'(rbuf[i]), exp_rd(off + i));
      check({req, " R6 rd_req count"}, req_cnt - r0, re);
      check({req, " R7 released"}, int'(sda_oe), 0);
   endtask

   // watchdog
   initial begin
      repeat (190000) @(posedge clk);
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual hung expected done");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin
      bit         a;
      bit [19:0]  wacks;
      int         s0;
      void'($urandom(32'd4711));
      for (int i = 0; i < NREG; i++) exp_bank[i] = 8'h00;
      repeat (5) @(negedge clk);
      rst_n = 1'b1;
      repeat (3) @(negedge clk);

      // R12: reset state
      check("R12 sda_oe", int'(sda_oe), 0);
      check("R12 wr_stb", int'(wr_stb), 0);
      check("R12 rd_req", int'(rd_req), 0);

      // R2: fill all registers
      for (int i = 0; i < 7; i++) wbuf[i] = 8'(8'h31 + 8'(i * 17));
      write_and_check("R2 full write", 0, 7, 7, -1);
      read_and_check("R5 read from 0", 0, 7);
      read_and_check("R6 read past end", 4, 5);
      read_and_check("R5 offset above range", 9, 1);

      // R3: zero count
      s0 = stb_cnt;
      write_xfer(2, 0, 1, -1, wacks);
      check("R3 zero count nack", int'(wacks[2]), 0);
      check("R3 no strobe", stb_cnt - s0, 0);
      cmp_bank("R3");

      // R4: bytes beyond the count
      wbuf[0] = 8'hA5; wbuf[1] = 8'h5A; wbuf[2] = 8'hC3;
      write_and_check("R4 overrun", 5, 1, 2, -1);

      // R13: count runs past the last register
      wbuf[0] = 8'h11; wbuf[1] = 8'h22; wbuf[2] = 8'h33; wbuf[3] = 8'h44;
      write_and_check("R13 past end", 5, 4, 4, -1);

      // R1: foreign address
      s0 = stb_cnt;
      m_start(); m_wbyte(8'hD4, -1, a); m_wbyte(8'h00, -1, a); m_stop();
      check("R1 foreign address nack", int'(a), 0);
      m_start(); m_wbyte(8'hD4, -1, a); m_stop();
      check("R1 foreign address nack", int'(a), 0);
      check("R1 no strobe", stb_cnt - s0, 0);

      // R8: read address without a preceding offset
      m_start(); m_wbyte(8'hD3, -1, a); m_stop();
      check("R8 bare read address nack", int'(a), 0);
      m_start(); m_wbyte(8'hD2, -1, a); m_wbyte(8'h01, -1, a); m_wbyte(8'h02, -1, a);
      m_start(); m_wbyte(8'hD3, -1, a); m_stop();
      check("R8 read address after count nack", int'(a), 0);
      check("R8 sda released", int'(sda_oe), 0);

      // R9: stop in the middle of a data byte
      s0 = stb_cnt;
      m_start(); m_wbyte(8'hD2, -1, a); m_wbyte(8'h01, -1, a); m_wbyte(8'h04, -1, a);
      m_wbyte(8'hAA, -1, a); m_wbyte(8'hBB, -1, a);
      for (int i = 0; i < 3; i++) begin
         m_sda = 1'b1; qw(); m_scl = 1'b1; qw(); qw(); m_scl = 1'b0; qw();
      end
      m_stop();
      exp_bank[1] = 8'hAA; exp_bank[2] = 8'hBB;
      check("R9 strobes before abort", stb_cnt - s0, 2);
      cmp_bank("R9");
      read_and_check("R9 after abort", 1, 3);

      // R10: short SDA glitch while SCL is high inside a data byte
      wbuf[0] = 8'hFF; wbuf[1] = 8'h3C;
      write_and_check("R10 glitch ignored", 3, 2, 2, 4);
      read_and_check("R10 readback", 3, 2);

      // random writes with read-back
      for (int t = 0; t < 6; t++) begin
         int off, cnt, nrd;
         off = int'($urandom_range(0, NREG - 1));
         cnt = int'($urandom_range(1, NREG - off));
         for (int i = 0; i < cnt; i++) wbuf[i] = 8'($urandom);
         write_and_check("R2 random write", off, cnt, cnt, -1);
         off = int'($urandom_range(0, NREG - 1));
         nrd = int'($urandom_range(1, NREG - off + 1));
         read_and_check("R5 random read", off, nrd);
      end

      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

endmodule